// File: doc/BRIEF.md
# Bit and Bit-Pair Test-and-Modify Unit

This unit performs the classic bit test, bit set, bit clear and bit change operations on a 32-bit data word. It also has a second mode that works on aligned two-bit fields. Each request arrives with the data word, a bit-selector byte and a two-bit operation code. One clock later the unit presents the modified word and the condition flags Z, C, N and V.

When the top bit of the selector is clear, the unit behaves like the familiar single-bit instruction. The low five selector bits pick the bit. Z receives the inverse of that bit as it was before the operation, and C, N and V keep their earlier values. When the top bit of the selector is set, the low four selector bits pick one of sixteen aligned pairs. The operation then applies to both bits of that pair. The pair's original two-bit value is reported one-hot across the flags: Z for 00, C for 01, N for 10 and V for 11.

The flags are held in state inside the unit, so a sequence of operations sees the carried-over C, N and V that single-bit mode preserves. Instruction decoding and operand storage belong to the surrounding pipeline.

Top module: `bitpair_unit`

## Requirements
- R1: While rst_n is low, result is 0, all four flags are 0 and res_valid is 0.
- R2: A request sampled with op_valid high at a rising edge appears on result and the flags after that same edge, and res_valid is high for exactly that one cycle.
- R3: With sel[7] = 0 the operation targets data bit sel[4:0]; sel[6:5] have no effect on result or flags.
- R4: In single-bit mode, Z becomes the inverse of the targeted bit as it was before modification, and C, N and V keep their previous values.
- R5: Operation codes: 2'b00 test (result equals data), 2'b01 change (invert the targeted bits), 2'b10 clear (targeted bits to 0), 2'b11 set (targeted bits to 1). No bit outside the targeted ones differs from data.
- R6: With sel[7] = 1 the operation targets data bits 2k+1 and 2k, where k = sel[3:0]; sel[6:4] have no effect.
- R7: In pair mode the flags are one-hot from the pair value before modification: 00 sets Z, 01 sets C, 10 sets N, 11 sets V, and the other three are cleared.
- R8: In pair mode, change, clear and set act on both bits of the selected pair.
- R9: While op_valid is low, result and the flags keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| sel | input | 8 | Bit selector; bit 7 chooses pair mode |
| data | input | 32 | Data word to test and modify |
| result | output | 32 | Modified data word |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (pair value 01) |
| flag_n | output | 1 | Negative flag (pair value 10) |
| flag_v | output | 1 | Overflow flag (pair value 11) |
| res_valid | output | 1 | High for one cycle after an accepted request |

## Verification
The assertions assume that op_code, sel and data are stable and known during every cycle in which op_valid is high. They also assume that op_valid itself is never unknown after reset. The stimulus drives all inputs at the falling edge, so every value is settled well before the edge that captures it. It also randomises sel across all 256 codes, including the don't-care bits 6:4 and 6:5. The idle cycles placed between requests carry fresh random data and selectors with op_valid low, so the hold rule is exercised against inputs that really do change.

// File: rtl/bitpair_pkg.sv
package bitpair_pkg;

   typedef enum logic [1:0] {
      OP_TEST   = 2'b00,
      OP_CHANGE = 2'b01,
      OP_CLEAR  = 2'b10,
      OP_SET    = 2'b11
   } bp_op_e;

   typedef struct packed {
      logic z;
      logic c;
      logic n;
      logic v;
   } bp_flags_t;

endpackage

// File: rtl/bitpair_target.sv
module bitpair_target
   import bitpair_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int SEL_W         = 8,
   parameter int PAIR_FLAG_BIT = 7,
   localparam int BIT_IDX_W    = $clog2(DATA_W),
   localparam int PAIRS        = DATA_W / 2,
   localparam int PAIR_IDX_W   = $clog2(PAIRS)
) (
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              pair_mode_o,
   output logic [DATA_W-1:0] mask_o,
   output logic              bit_val_o,
   output logic [1:0]        pair_val_o
);

   logic [BIT_IDX_W-1:0]  bit_idx;
   logic [PAIR_IDX_W-1:0] pair_idx;
   logic                  unused_sel_bits;

   assign pair_mode_o     = sel_i[PAIR_FLAG_BIT];
   assign bit_idx         = sel_i[BIT_IDX_W-1:0];
   assign pair_idx        = sel_i[PAIR_IDX_W-1:0];
   assign unused_sel_bits = ^sel_i;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign mask_o[i] = pair_mode_o ? (pair_idx == PAIR_IDX_W'(i / 2))
                                        : (bit_idx  == BIT_IDX_W'(i));
      end
   endgenerate

   assign bit_val_o  = data_i[bit_idx];
   assign pair_val_o = data_i[{pair_idx, 1'b0} +: 2];

   always_comb begin
      AST_MASK_COUNT: assert ($isunknown(sel_i) ||
         $countones(mask_o) == (pair_mode_o ? 2 : 1)); // R6
   end

endmodule

// File: rtl/bitpair_modify.sv
module bitpair_modify
   import bitpair_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  bp_op_e            op_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic [DATA_W-1:0] data_o
);

   always_comb begin
      unique case (op_i)
         OP_TEST:   data_o = data_i;
         OP_CHANGE: data_o = data_i ^ mask_i;
         OP_CLEAR:  data_o = data_i & ~mask_i;
         OP_SET:    data_o = data_i | mask_i;
         default:   data_o = data_i;
      endcase
   end

endmodule

// File: rtl/bitpair_flags.sv
module bitpair_flags
   import bitpair_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      valid_i,
   input  logic      pair_mode_i,
   input  logic      bit_val_i,
   input  logic [1:0] pair_val_i,
   output bp_flags_t flags_o
);

   bp_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (valid_i) begin
         if (pair_mode_i) begin
            flags_q.z <= (pair_val_i == 2'b00);
            flags_q.c <= (pair_val_i == 2'b01);
            flags_q.n <= (pair_val_i == 2'b10);
            flags_q.v <= (pair_val_i == 2'b11);
         end else begin
            flags_q.z <= ~bit_val_i;
         end
      end
   end

   assign flags_o = flags_q;

   AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && pair_mode_i) |=> ($countones(flags_q) == 1)); // R7

   AST_SINGLE_KEEPS_CNV: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !pair_mode_i) |=> $stable({flags_q.c, flags_q.n, flags_q.v})); // R4

   AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(flags_q)); // R9

endmodule

// File: rtl/bitpair_unit.sv
module bitpair_unit
   import bitpair_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int SEL_W         = 8,
   parameter int PAIR_FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] result,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_v,
   output logic              res_valid
);

   localparam int BIT_IDX_W = $clog2(DATA_W);

   initial begin
      AST_DATA_W_POW2: assert (DATA_W >= 4 && (DATA_W & (DATA_W - 1)) == 0);
      AST_FLAG_BIT_RANGE: assert (PAIR_FLAG_BIT < SEL_W && PAIR_FLAG_BIT >= BIT_IDX_W);
   end

   logic              pair_mode;
   logic [DATA_W-1:0] mask;
   logic              bit_val;
   logic [1:0]        pair_val;
   logic [DATA_W-1:0] next_data;
   bp_flags_t         flags;
   logic [DATA_W-1:0] result_q;
   logic              valid_q;

   bitpair_target #(
      .DATA_W        (DATA_W),
      .SEL_W         (SEL_W),
      .PAIR_FLAG_BIT (PAIR_FLAG_BIT)
   ) u_target (
      .sel_i       (sel),
      .data_i      (data),
      .pair_mode_o (pair_mode),
      .mask_o      (mask),
      .bit_val_o   (bit_val),
      .pair_val_o  (pair_val)
   );

   bitpair_modify #(
      .DATA_W (DATA_W)
   ) u_modify (
      .op_i   (bp_op_e'(op_code)),
      .data_i (data),
      .mask_i (mask),
      .data_o (next_data)
   );

   bitpair_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_i     (op_valid),
      .pair_mode_i (pair_mode),
      .bit_val_i   (bit_val),
      .pair_val_i  (pair_val),
      .flags_o     (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= op_valid;
         if (op_valid) begin
            result_q <= next_data;
         end
      end
   end

   assign result    = result_q;
   assign res_valid = valid_q;
   assign flag_z    = flags.z;
   assign flag_c    = flags.c;
   assign flag_n    = flags.n;
   assign flag_v    = flags.v;

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid); // R2

   AST_TEST_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'b00) |=> (result == $past(data))); // R5

   AST_ONLY_TARGET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (((result ^ $past(data)) & ~$past(mask)) == '0)); // R5

   AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(result) && !res_valid)); // R9

endmodule

// File: tb/bitpair_unit_tb.sv
module bitpair_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [1:0]  op_code;
   logic [7:0]  sel;
   logic [31:0] data;
   logic [31:0] result;
   logic        flag_z, flag_c, flag_n, flag_v, res_valid;

   int checks = 0;
   int errors = 0;
   logic m_z = 1'b0, m_c = 1'b0, m_n = 1'b0, m_v = 1'b0;
   logic [31:0] m_res = '0;

   always #2 clk = ~clk;

   bitpair_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .sel       (sel),
      .data      (data),
      .result    (result),
      .flag_z    (flag_z),
      .flag_c    (flag_c),
      .flag_n    (flag_n),
      .flag_v    (flag_v),
      .res_valid (res_valid)
   );

   function automatic logic [31:0] tgt_mask(input logic [7:0] s);
      if (s[7]) return 32'h3 << (2 * s[3:0]);
      return 32'h1 << s[4:0];
   endfunction

   function automatic logic [31:0] exp_result(input logic [1:0] op, input logic [7:0] s,
                                              input logic [31:0] d);
      logic [31:0] m = tgt_mask(s);
      case (op)
         2'b00:   return d;
         2'b01:   return d ^ m;
         2'b10:   return d & ~m;
         default: return d | m;
      endcase
   endfunction

   task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic observe(input string req, input logic vld);
      check(req, {result, flag_z, flag_c, flag_n, flag_v, res_valid},
                 {m_res, m_z, m_c, m_n, m_v, vld});
   endtask

   task automatic run(input logic [1:0] op, input logic [7:0] s, input logic [31:0] d,
                      input string req);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; sel = s; data = d;
      m_res = exp_result(op, s, d);
      if (s[7]) begin
         logic [1:0] pv = 2'((d >> (2 * s[3:0])) & 32'h3);
         m_z = (pv == 2'd0); m_c = (pv == 2'd1); m_n = (pv == 2'd2); m_v = (pv == 2'd3);
      end else begin
         m_z = ~d[s[4:0]];
      end
      @(negedge clk);
      op_valid = 1'b0;
      observe(req, 1'b1);
   endtask

   task automatic idle_check();
      op_valid = 1'b0;
      op_code = 2'($urandom); sel = 8'($urandom); data = $urandom;
      @(negedge clk);
      observe("R9 idle hold", 1'b0);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; op_valid = 1'b0; op_code = '0; sel = '0; data = '0;
      repeat (3) @(negedge clk);
      observe("R1 reset state", 1'b0);
      op_valid = 1'b1; data = 32'hFFFF_FFFF; sel = 8'h85; op_code = 2'b11;
      @(negedge clk);
      observe("R1 reset ignores request", 1'b0);
      op_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      run(2'b00, 8'h1F, 32'h8000_0000, "R3 R4 test bit 31");
      run(2'b00, 8'h00, 32'hFFFF_FFFE, "R4 test bit 0 clear");
      run(2'b11, 8'h63, 32'h0000_0000, "R3 bits 6:5 ignored set bit 3");
      run(2'b01, 8'h0A, 32'h0000_0400, "R5 change bit 10");
      run(2'b10, 8'h10, 32'hFFFF_FFFF, "R5 clear bit 16");
      run(2'b00, 8'h8F, 32'hC000_0000, "R6 R7 pair 15 value 11");
      run(2'b00, 8'h00, 32'h0000_0001, "R4 single keeps V");
      run(2'b00, 8'hF0, 32'h0000_0001, "R6 bits 6:4 ignored pair 0 value 01");
      run(2'b00, 8'h81, 32'h0000_0008, "R7 pair 1 value 10");
      run(2'b11, 8'h82, 32'h0000_0000, "R7 R8 pair set from 00");
      run(2'b10, 8'h83, 32'hFFFF_FFFF, "R8 pair clear from 11");
      run(2'b01, 8'h84, 32'h0000_0100, "R8 pair change from 01");
      idle_check();
      idle_check();

      for (int i = 0; i < 400; i++) begin
         run(2'($urandom), 8'($urandom), $urandom, "R2 R3 R5 R6 R7 random");
         if (($urandom % 4) == 0) idle_check();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule